// File: doc/BRIEF.md
# MAC address table operation engine

This block is the command engine behind a small learned-address table in an Ethernet switch. A host programs a few 16-bit registers (operation, entry data, three MAC address words, a control word and an extended database word), then starts a command by writing an operation code with the busy bit set. The engine walks the table one slot per clock and clears busy when it is done. The host polls busy before it reads results or issues the next command.

Four command families are supported. A load writes or replaces one entry, and the same command with a zero state purges that entry. Get-next returns the entry that follows a given MAC address in ascending order within one database, which lets software walk a database. Flush removes entries. Move rewrites the port bitmaps of entries. Flush and move share four operation codes, and the state nibble in the data register selects between them. The codes differ in whether static entries are spared and whether only one database is affected.

Top module: `mac_table_engine`

## Requirements
- R1: After reset every register reads 0, busy is low and the table holds no entries, so a get-next returns state 0.
- R2: Writing address 0 with bit 15 set starts a command. Busy rises on the next edge and stays high for exactly N_ENT+1 = 17 cycles. Without such a write, busy stays low.
- R3: Register map: 0 operation (bit 15 busy, bits 14:12 opcode, bits 3:0 database low nibble), 1 data, 2/3/4 MAC words, 5 control (bits 15:12 database high nibble), 6 extended database. In the data word, bits 3:0 hold the state (0 = unused), bits 11:4 hold the port bitmap and bit 15 holds the trunk flag. MAC byte 0 sits in bits 15:8 of word 2 and byte 5 in bits 7:0 of word 4.
- R4: Load (opcode 1) with a nonzero state replaces an entry with the same MAC and database. Otherwise it fills the lowest free slot. When the table is full, the load is dropped.
- R5: Load with state 0 removes the entry with the same MAC and database, if there is one.
- R6: Get-next (opcode 4) returns in the data and MAC registers the valid entry of the selected database with the smallest MAC above the MAC registers. An all-ones start returns the smallest entry. When no entry is left, it returns data 0 and an all-ones MAC.
- R7: With data state 0, opcodes 2 and 3 flush across every database, and opcodes 5 and 6 flush only the selected database. Opcodes 2 and 5 also flush static entries.
- R8: State 0xF marks an entry as static. Opcodes 3 and 6 leave static entries untouched for both flush and move.
- R9: With data state 0xF the command is a move. Data bits 7:4 hold the source port and bits 11:8 hold the destination port; this field is shifted by the number of set bits in the 4-bit move mask. Every selected entry whose bitmap has the source bit loses that bit and gains the destination bit.
- R10: A move whose destination equals the full mask (0xF) removes every selected entry that has the source bit.
- R11: The database number is {control[15:12], operation[3:0]}. Commands never see or change entries of another database.
- R12: While busy is high, every register write, including a new start, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| busy | output | 1 | Command in progress |

## Verification
The hardest cases to reach are those where the table contents interact with a command. Examples are a full table dropping a load, a move whose source and destination bits both exist, and a static entry that survives one flush variant but not another. None of these is visible except through get-next walks. The stimulus therefore builds up a table across two databases that differ only in the high nibble of the database number. It applies moves, removals and each flush variant in turn, and after every step it walks the affected databases completely. It also fills one database past capacity, and it writes to registers in the middle of a command to show that nothing changes.

// File: rtl/mac_table_engine.sv
module mac_table_engine #(
  parameter int N_ENT = 16,
  parameter int NPORT = 8,
  parameter logic [10:0] MOVE_MASK = 11'h00F,
  parameter logic [3:0] STATIC_ST = 4'hF,
  parameter bit BIG_DB = 1'b0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        busy
);
  localparam int IW = $clog2(N_ENT);

  function automatic int popc(input logic [10:0] m);
    int c;
    c = 0;
    for (int i = 0; i < 11; i++) c += int'(m[i]);
    return c;
  endfunction
  localparam int SHIFT = popc(MOVE_MASK);

  localparam logic [2:0] OPC_LOAD = 3'd1, OPC_NEXT = 3'd4;

  logic [3:0]       t_st  [N_ENT];
  logic [47:0]      t_mac [N_ENT];
  logic [11:0]      t_db  [N_ENT];
  logic [NPORT-1:0] t_pv  [N_ENT];
  logic             t_tr  [N_ENT];

  logic [14:0] op_q;
  logic        busy_q, fin_q;
  logic [IW-1:0] idx_q, hit_i, free_i, best_i;
  logic        hit_f, free_f, best_f;
  logic [47:0] best_mac;
  logic [15:0] data_q, ctrl_q, dbx_q;
  logic [47:0] mac_q;

  wire [2:0]  opc    = op_q[14:12];
  wire [11:0] cmd_db = BIG_DB ? dbx_q[11:0] : {4'd0, ctrl_q[15:12], op_q[3:0]};
  wire [3:0]  cur_st = t_st[idx_q];
  wire        cur_v  = cur_st != 4'd0;
  wire        cur_in = cur_v && t_db[idx_q] == cmd_db;
  wire        cur_key = cur_in && t_mac[idx_q] == mac_q;
  wire        nx_cand = cur_in && (&mac_q || t_mac[idx_q] > mac_q) &&
                        (!best_f || t_mac[idx_q] < best_mac);

  wire        is_fm  = opc == 3'd2 || opc == 3'd3 || opc == 3'd5 || opc == 3'd6;
  wire        fm_one = opc == 3'd5 || opc == 3'd6;
  wire        fm_ns  = opc == 3'd3 || opc == 3'd6;
  wire        fm_hit = cur_v && (!fm_one || t_db[idx_q] == cmd_db) &&
                       (!fm_ns || cur_st != STATIC_ST);

  wire [10:0] vec = data_q[14:4];
  wire [10:0] src = vec & MOVE_MASK;
  wire [10:0] dst = (vec >> SHIFT) & MOVE_MASK;
  wire [NPORT-1:0] one_p   = {{(NPORT-1){1'b0}}, 1'b1};
  wire [NPORT-1:0] src_bit = one_p << src;
  wire [NPORT-1:0] dst_bit = one_p << dst;

  wire [3:0]       ld_st = data_q[3:0];
  wire [NPORT-1:0] ld_pv = data_q[4 +: NPORT];
  wire             last  = idx_q == IW'(N_ENT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; busy_q <= 1'b0; fin_q <= 1'b0; idx_q <= '0;
      hit_f <= 1'b0; free_f <= 1'b0; best_f <= 1'b0;
      hit_i <= '0; free_i <= '0; best_i <= '0; best_mac <= '0;
      data_q <= '0; ctrl_q <= '0; dbx_q <= '0; mac_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        t_st[i] <= '0; t_mac[i] <= '0; t_db[i] <= '0; t_pv[i] <= '0; t_tr[i] <= 1'b0;
      end
    end else begin
      if (wr_en && !busy_q) begin
        case (wr_addr)
          3'd0: begin
            op_q <= wr_data[14:0];
            if (wr_data[15]) begin
              busy_q <= 1'b1; fin_q <= 1'b0; idx_q <= '0;
              hit_f <= 1'b0; free_f <= 1'b0; best_f <= 1'b0;
            end
          end
          3'd1: data_q <= wr_data;
          3'd2: mac_q[47:32] <= wr_data;
          3'd3: mac_q[31:16] <= wr_data;
          3'd4: mac_q[15:0]  <= wr_data;
          3'd5: ctrl_q <= wr_data;
          3'd6: dbx_q  <= wr_data;
          default: ;
        endcase
      end

      if (busy_q && !fin_q) begin
        if (opc == OPC_LOAD) begin
          if (cur_key && !hit_f) begin hit_f <= 1'b1; hit_i <= idx_q; end
          if (!cur_v && !free_f) begin free_f <= 1'b1; free_i <= idx_q; end
        end
        if (opc == OPC_NEXT && nx_cand) begin
          best_f <= 1'b1; best_i <= idx_q; best_mac <= t_mac[idx_q];
        end
        if (is_fm && fm_hit) begin
          if (data_q[3:0] == 4'h0) t_st[idx_q] <= 4'h0;
          else if (data_q[3:0] == 4'hF && |(t_pv[idx_q] & src_bit)) begin
            if (dst == MOVE_MASK) t_st[idx_q] <= 4'h0;
            else t_pv[idx_q] <= (t_pv[idx_q] & ~src_bit) | dst_bit;
          end
        end
        idx_q <= idx_q + 1'b1;
        if (last) fin_q <= 1'b1;
      end

      if (fin_q) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b0;
        if (opc == OPC_LOAD) begin
          if (ld_st != 4'h0) begin
            if (hit_f || free_f) begin
              t_st[hit_f ? hit_i : free_i]  <= ld_st;
              t_mac[hit_f ? hit_i : free_i] <= mac_q;
              t_db[hit_f ? hit_i : free_i]  <= cmd_db;
              t_pv[hit_f ? hit_i : free_i]  <= ld_pv;
              t_tr[hit_f ? hit_i : free_i]  <= data_q[15];
            end
          end else if (hit_f) t_st[hit_i] <= 4'h0;
        end
        if (opc == OPC_NEXT) begin
          if (best_f) begin
            data_q <= {t_tr[best_i], 11'(t_pv[best_i]), t_st[best_i]};
            mac_q  <= t_mac[best_i];
          end else begin
            data_q <= '0;
            mac_q  <= '1;
          end
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = {busy_q, op_q};
      3'd1: rd_data = data_q;
      3'd2: rd_data = mac_q[47:32];
      3'd3: rd_data = mac_q[31:16];
      3'd4: rd_data = mac_q[15:0];
      3'd5: rd_data = ctrl_q;
      3'd6: rd_data = dbx_q;
      default: rd_data = '0;
    endcase
  end

  assign busy = busy_q;
endmodule

// File: rtl/mac_table_engine_chk.sv
module mac_table_engine_chk #(
  parameter int N_ENT = 16
)(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        go_bit,
  input logic        busy,
  input logic [15:0] ctrl,
  input logic [15:0] dbx
);
  int cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (busy) cnt <= cnt + 1;
    else cnt <= 0;
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 3'd0 && go_bit) |=> busy);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(wr_en && wr_addr == 3'd0 && go_bit)) |=> !busy);

  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= N_ENT);

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt == N_ENT + 1);

  assert_hold_regs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(ctrl) && $stable(dbx)));
endmodule

bind mac_table_engine mac_table_engine_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .go_bit(wr_data[15]), .busy(busy), .ctrl(ctrl_q), .dbx(dbx_q)
);

// File: tb/sim_mac_table_engine.sv
`timescale 1ns/1ps
module sim_mac_table_engine;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic busy;

  mac_table_engine u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  logic [3:0]  m_st  [16];
  logic [47:0] m_mac [16];
  logic [11:0] m_db  [16];
  logic [7:0]  m_pv  [16];
  logic        m_tr  [16];
  logic [15:0] m_op = '0, m_data = '0, m_ctrl = '0, m_dbx = '0;
  logic [47:0] m_mac_r = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_exec(input logic [2:0] opc);
    logic [11:0] sel;
    int j, f, b;
    logic [3:0] s, src, dst;
    sel = {4'd0, m_ctrl[15:12], m_op[3:0]};
    if (opc == 3'd1) begin
      j = -1; f = -1;
      for (int i = 0; i < 16; i++) begin
        if (m_st[i] != 0 && m_mac[i] == m_mac_r && m_db[i] == sel && j < 0) j = i;
        if (m_st[i] == 0 && f < 0) f = i;
      end
      if (m_data[3:0] != 0) begin
        if (j < 0) j = f;
        if (j >= 0) begin
          m_st[j] = m_data[3:0]; m_mac[j] = m_mac_r; m_db[j] = sel;
          m_pv[j] = m_data[11:4]; m_tr[j] = m_data[15];
        end
      end else if (j >= 0) m_st[j] = 0;
    end else if (opc == 3'd4) begin
      b = -1;
      for (int i = 0; i < 16; i++)
        if (m_st[i] != 0 && m_db[i] == sel && (m_mac_r == '1 || m_mac[i] > m_mac_r) &&
            (b < 0 || m_mac[i] < m_mac[b])) b = i;
      if (b >= 0) begin
        m_data = {m_tr[b], 3'b000, m_pv[b], m_st[b]};
        m_mac_r = m_mac[b];
      end else begin
        m_data = '0; m_mac_r = '1;
      end
    end else if (opc == 3'd2 || opc == 3'd3 || opc == 3'd5 || opc == 3'd6) begin
      s = m_data[3:0]; src = m_data[7:4]; dst = m_data[11:8];
      for (int i = 0; i < 16; i++) begin
        if (m_st[i] == 0) continue;
        if ((opc == 3'd5 || opc == 3'd6) && m_db[i] != sel) continue;
        if ((opc == 3'd3 || opc == 3'd6) && m_st[i] == 4'hF) continue;
        if (s == 4'h0) m_st[i] = 0;
        else if (s == 4'hF && src < 8 && m_pv[i][src[2:0]]) begin
          if (dst == 4'hF) m_st[i] = 0;
          else begin
            m_pv[i][src[2:0]] = 1'b0;
            if (dst < 8) m_pv[i][dst[2:0]] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    case (a)
      3'd1: m_data = d;
      3'd2: m_mac_r[47:32] = d;
      3'd3: m_mac_r[31:16] = d;
      3'd4: m_mac_r[15:0] = d;
      3'd5: m_ctrl = d;
      3'd6: m_dbx = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmp_regs(input string tag);
    logic [15:0] exp;
    for (int a = 0; a < 7; a++) begin
      rd_addr = 3'(a);
      #1;
      case (a)
        0: exp = m_op; 1: exp = m_data; 2: exp = m_mac_r[47:32];
        3: exp = m_mac_r[31:16]; 4: exp = m_mac_r[15:0]; 5: exp = m_ctrl;
        default: exp = m_dbx;
      endcase
      check(tag, 64'(rd_data), 64'(exp));
    end
  endtask

  task automatic cmd(input logic [2:0] opc, input logic [3:0] lo, input string tag, input bit poke = 1'b0);
    bit ok;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = {1'b1, opc, 8'h00, lo};
    m_op = {1'b0, opc, 8'h00, lo};
    m_exec(opc);
    @(negedge clk);
    wr_en = 1'b0;
    ok = 1'b1;
    for (int k = 0; k < 17; k++) begin
      if (busy !== 1'b1) ok = 1'b0;
      if (poke && k == 4) begin wr_en = 1'b1; wr_addr = 3'd5; wr_data = 16'hABCD; end
      else if (poke && k == 5) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'hA001; end
      else if (poke && k == 6) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h1234; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R2 busy high 17 cycles", 64'(ok), 64'd1);
    check("R2 busy clears", 64'(busy), 64'd0);
    cmp_regs(tag);
  endtask

  task automatic load(input logic [47:0] mac, input logic [3:0] st, input logic [7:0] pv,
                      input logic tr, input logic [3:0] lo, input string tag);
    wreg(3'd2, mac[47:32]); wreg(3'd3, mac[31:16]); wreg(3'd4, mac[15:0]);
    wreg(3'd1, {tr, 3'b000, pv, st});
    cmd(3'd1, lo, tag);
  endtask

  task automatic walk(input logic [3:0] lo, input string tag, output int cnt);
    cnt = 0;
    wreg(3'd2, 16'hFFFF); wreg(3'd3, 16'hFFFF); wreg(3'd4, 16'hFFFF);
    for (int k = 0; k < 18; k++) begin
      cmd(3'd4, lo, tag);
      if (m_data[3:0] == 4'h0) break;
      cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int c;
    for (int i = 0; i < 16; i++) begin
      m_st[i] = 0; m_mac[i] = 0; m_db[i] = 0; m_pv[i] = 0; m_tr[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'd0);
    cmp_regs("R1 reset register value");
    walk(4'd1, "R1 empty table", c);
    check("R1 empty walk count", 64'(c), 64'd0);

    load(48'h001122334410, 4'h7, 8'h03, 1'b0, 4'd1, "R4 load A");
    load(48'h001122334405, 4'hF, 8'h04, 1'b1, 4'd1, "R4 load B static trunk");
    load(48'h001122334407, 4'h7, 8'h01, 1'b0, 4'd2, "R11 load C other db");
    load(48'h001122334420, 4'h3, 8'h02, 1'b0, 4'd1, "R4 load D");
    load(48'hFE0000000001, 4'h5, 8'h01, 1'b0, 4'd1, "R3 load E high byte");
    walk(4'd1, "R6 R3 ascending walk", c);
    check("R6 walk count db1", 64'(c), 64'd4);

    load(48'h001122334410, 4'h5, 8'h80, 1'b0, 4'd1, "R4 overwrite A");
    walk(4'd1, "R4 walk after overwrite", c);
    check("R4 overwrite keeps count", 64'(c), 64'd4);

    load(48'h001122334420, 4'h0, 8'h00, 1'b0, 4'd1, "R5 purge D");
    walk(4'd1, "R5 walk after purge", c);
    check("R5 purge count", 64'(c), 64'd3);

    wreg(3'd5, 16'h2000);
    load(48'h00AA00BB00CC, 4'h6, 8'h10, 1'b0, 4'd1, "R11 load F db 0x21");
    walk(4'd1, "R11 walk db 0x21", c);
    check("R11 high nibble db count", 64'(c), 64'd1);
    wreg(3'd5, 16'h0000);
    walk(4'd1, "R11 walk db 1", c);
    check("R11 db 1 count", 64'(c), 64'd3);

    wreg(3'd1, 16'h060F);
    cmd(3'd6, 4'd1, "R9 R8 move nonstatic db1 0->6");
    walk(4'd1, "R9 walk db1 after move", c);
    walk(4'd2, "R11 db2 untouched by move", c);
    check("R11 db2 count", 64'(c), 64'd1);

    wreg(3'd1, 16'h032F);
    cmd(3'd2, 4'd1, "R9 move all dbs static 2->3");
    walk(4'd1, "R9 walk static moved", c);

    wreg(3'd1, 16'h0F0F);
    cmd(3'd3, 4'd1, "R10 remove port 0 all dbs");
    walk(4'd2, "R10 walk db2 after remove", c);
    check("R10 removed count", 64'(c), 64'd0);

    wreg(3'd1, 16'h0000);
    cmd(3'd6, 4'd1, "R7 R8 flush nonstatic db1");
    walk(4'd1, "R8 static survives", c);
    check("R8 static count", 64'(c), 64'd1);

    wreg(3'd2, 16'h0000); wreg(3'd3, 16'h0000); wreg(3'd4, 16'h0042);
    wreg(3'd1, 16'h0017);
    cmd(3'd1, 4'd1, "R12 writes while busy ignored", 1'b1);
    walk(4'd1, "R12 walk after poke", c);
    check("R12 no restart flush", 64'(c), 64'd2);

    wreg(3'd1, 16'h0000);
    cmd(3'd2, 4'd0, "R7 flush all dbs");
    walk(4'd1, "R7 db1 empty", c);
    check("R7 db1 count", 64'(c), 64'd0);
    wreg(3'd5, 16'h2000);
    walk(4'd1, "R7 db 0x21 empty", c);
    check("R7 db 0x21 count", 64'(c), 64'd0);
    wreg(3'd5, 16'h0000);

    for (int i = 0; i < 17; i++)
      load(48'h000000000100 + 48'(i), 4'h7, 8'h01, 1'b0, 4'd3, "R4 fill");
    walk(4'd3, "R4 full table walk", c);
    check("R4 full table drops extra", 64'(c), 64'd16);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule